// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Sequencer

This block drives a one-time-programmable fuse array from a small word-addressed register file. Software loads the staging words (data words followed by check words), writes a 16-bit operation key, and then writes the command register with a read or program request and a 2-bit block number. The sequencer then runs a timed sequence on the array control pins and raises a done interrupt when it finishes.

A program operation raises the supply enable and waits a power-up count. It then visits every staged bit in ascending order. Each bit gets a setup, burn and hold phase, and the burn strobe fires only for bits that are 1. A power-off wait closes the operation. A read operation holds the load pin, waits an initial delay, and then runs one setup, strobe and hold phase per word. Each word is captured into a readback buffer. Every phase length comes from a software-writable timing register.

Top module: `fuse_sequencer`

## Requirements
- R1: A command write starts an operation only when the key register holds 0x5A5A for a program (command bit 1) or 0x5AA5 for a read (command bit 0). Otherwise the write is dropped: the command register (address 0x11) reads back 0, the state stays idle, and the array is not touched.
- R2: When both command bits are written as 1 together, only the read is considered. With the read key present, a read runs and only the read-done raw bit (bit 0) sets.
- R3: An accepted command bit reads back as 1 in the command register while its operation runs. It clears by itself when the operation completes.
- R4: A command register write while a command bit is pending is ignored entirely, including its block number. No second operation follows the running one.
- R5: A program operation burns exactly the staged 1 bits into the block given by command bits [3:2], at bit address word*32+bit. Other blocks and the 0 bits are left unchanged, so repeated programs accumulate as a bitwise OR.
- R6: During a program, the supply enable is high for power-up + N*(setup+hold) + ones*one-pulse + zeros*zero-pulse cycles, where N is the number of staged bits. The strobe is high for ones*one-pulse cycles. Chip select and program enable (both active low) stay low from the first bit's setup to the last bit's hold.
- R7: A read of a block captures each staged-size word into the readback buffer at addresses 0x20 upward. Load is high for init + W*(setup+pulse+hold) cycles and the strobe for W*pulse cycles, where W is the number of words.
- R8: The read-done and program-done events set raw bits 0 and 1 (address 0x17). The status register (0x19) and the interrupt output show raw AND enable (0x18). Writing 1s to 0x1A clears the matching raw bits.
- R9: Status register 0x16 shows the FSM state in [3:0] (idle 0, power-up wait 5) and the live pins: load [4], supply enable [5], strobe [6], chip select [7], program enable [8].
- R10: After reset, the timing registers read 0x12010201 (read init 18, hold 1, pulse 2, setup 1), 0x00C80101 (one-pulse 200, zero-pulse 1, program setup 1), 0x00300001 (power-up 12288, program hold 1) and 0x00000190 (power-off 400). The pins are idle and status reads 0x180.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 6 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| fuseCsN | output | 1 | Array chip select, active low |
| fusePgmN | output | 1 | Array program enable, active low |
| fuseStrobe | output | 1 | Array read/burn strobe |
| fuseLoad | output | 1 | Array read load enable |
| fuseVddq | output | 1 | Programming supply enable |
| fuseBlk | output | 2 | Selected block |
| fuseAddr | output | WORD_AW+5 | Bit address; word start during reads |
| fuseRdata | input | 32 | Array read word at fuseAddr |
| irq | output | 1 | OR of enabled interrupt status bits |

## Verification
The bench builds the sequencer with two data words and one check word, which gives 96 staged bits. A full program of every bit then takes a few hundred cycles, and the bit walk, last-bit and last-word turns, and cross-block OR accumulation can all be reached many times over. The bench also rewrites the timing registers to small distinct values (one-pulse 3, zero-pulse 2, power-up 5). With those values, every phase count shows up separately in the measured pin-high cycle totals.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_RD_INIT   = 4'd1,
    ST_RD_SETUP  = 4'd2,
    ST_RD_PULSE  = 4'd3,
    ST_RD_HOLD   = 4'd4,
    ST_PG_PWRON  = 4'd5,
    ST_PG_SETUP  = 4'd6,
    ST_PG_PULSE  = 4'd7,
    ST_PG_HOLD   = 4'd8,
    ST_PG_PWROFF = 4'd9
  } seq_state_e;

  // one-cycle events from control to datapath
  typedef struct packed {
    logic capture;
    logic rdDone;
    logic pgmDone;
  } seq_strobe_t;

  typedef struct packed {
    logic [7:0]  rdInit;
    logic [7:0]  rdSetup;
    logic [7:0]  rdPulse;
    logic [7:0]  rdHold;
    logic [7:0]  pgSetup;
    logic [7:0]  pgHold;
    logic [7:0]  pgZero;
    logic [15:0] pgOne;
    logic [15:0] pwrOn;
    logic [15:0] pwrOff;
  } seq_timing_t;

  localparam logic [15:0] KEY_PGM = 16'h5A5A;
  localparam logic [15:0] KEY_RD  = 16'h5AA5;

  localparam logic [5:0] A_KEY    = 6'h10;
  localparam logic [5:0] A_CMD    = 6'h11;
  localparam logic [5:0] A_RDTIM  = 6'h12;
  localparam logic [5:0] A_PGTIM0 = 6'h13;
  localparam logic [5:0] A_PGTIM1 = 6'h14;
  localparam logic [5:0] A_PWROFF = 6'h15;
  localparam logic [5:0] A_STATUS = 6'h16;
  localparam logic [5:0] A_INTRAW = 6'h17;
  localparam logic [5:0] A_INTENA = 6'h18;
  localparam logic [5:0] A_INTST  = 6'h19;
  localparam logic [5:0] A_INTCLR = 6'h1A;

endpackage

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
  import fuse_seq_pkg::*;
#(
  parameter int STAGE_WORDS = 11,
  parameter int WORD_AW = 4,
  parameter int BIT_AW = WORD_AW + 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startRd,
  input  logic              startPgm,
  input  seq_timing_t       tim,
  input  logic              curBit,
  output seq_state_e        state,
  output seq_strobe_t       strb,
  output logic [BIT_AW-1:0] bitIdx,
  output logic              csN,
  output logic              pgmN,
  output logic              strobe,
  output logic              load,
  output logic              vddq
);

  localparam int TOTAL_BITS = STAGE_WORDS * 32;
  localparam logic [BIT_AW-1:0]  LAST_BIT  = BIT_AW'(TOTAL_BITS - 1);
  localparam logic [WORD_AW-1:0] LAST_WORD = WORD_AW'(STAGE_WORDS - 1);

  logic [15:0] cnt;
  logic        cntZero, lastBit, lastWord;

  assign cntZero  = (cnt == 16'd0);
  assign lastBit  = (bitIdx == LAST_BIT);
  assign lastWord = (bitIdx[BIT_AW-1:5] == LAST_WORD);

  // a programmed count of 0 behaves as 1 cycle
  function automatic logic [15:0] ld(input logic [15:0] c);
    return (c == 16'd0) ? 16'd0 : c - 16'd1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (state == ST_IDLE) begin
      bitIdx <= '0;
      if (startRd) begin
        state <= ST_RD_INIT;
        cnt   <= ld({8'd0, tim.rdInit});
      end else if (startPgm) begin
        state <= ST_PG_PWRON;
        cnt   <= ld(tim.pwrOn);
      end
    end else if (!cntZero) begin
      cnt <= cnt - 16'd1;
    end else begin
      unique case (state)
        ST_RD_INIT: begin
          state <= ST_RD_SETUP;
          cnt   <= ld({8'd0, tim.rdSetup});
        end
        ST_RD_SETUP: begin
          state <= ST_RD_PULSE;
          cnt   <= ld({8'd0, tim.rdPulse});
        end
        ST_RD_PULSE: begin
          state <= ST_RD_HOLD;
          cnt   <= ld({8'd0, tim.rdHold});
        end
        ST_RD_HOLD: begin
          if (lastWord) begin
            state <= ST_IDLE;
          end else begin
            bitIdx <= bitIdx + BIT_AW'(32);
            state  <= ST_RD_SETUP;
            cnt    <= ld({8'd0, tim.rdSetup});
          end
        end
        ST_PG_PWRON: begin
          state <= ST_PG_SETUP;
          cnt   <= ld({8'd0, tim.pgSetup});
        end
        ST_PG_SETUP: begin
          state <= ST_PG_PULSE;
          cnt   <= curBit ? ld(tim.pgOne) : ld({8'd0, tim.pgZero});
        end
        ST_PG_PULSE: begin
          state <= ST_PG_HOLD;
          cnt   <= ld({8'd0, tim.pgHold});
        end
        ST_PG_HOLD: begin
          if (lastBit) begin
            state <= ST_PG_PWROFF;
            cnt   <= ld(tim.pwrOff);
          end else begin
            bitIdx <= bitIdx + BIT_AW'(1);
            state  <= ST_PG_SETUP;
            cnt    <= ld({8'd0, tim.pgSetup});
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic inRead, inBurn;
  assign inRead = (state == ST_RD_SETUP) || (state == ST_RD_PULSE) || (state == ST_RD_HOLD);
  assign inBurn = (state == ST_PG_SETUP) || (state == ST_PG_PULSE) || (state == ST_PG_HOLD);

  always_comb begin
    load   = inRead || (state == ST_RD_INIT);
    csN    = !(inRead || inBurn);
    pgmN   = !inBurn;
    vddq   = inBurn || (state == ST_PG_PWRON);
    strobe = (state == ST_RD_PULSE) || ((state == ST_PG_PULSE) && curBit);
    strb.capture = (state == ST_RD_PULSE) && cntZero;
    strb.rdDone  = (state == ST_RD_HOLD) && cntZero && lastWord;
    strb.pgmDone = (state == ST_PG_PWROFF) && cntZero;
  end

  // R4
  leave_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) == ST_IDLE) |-> $past(startRd || startPgm));

  // R6
  pgm_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgmN) |-> (state == ST_PG_PWROFF));

endmodule

// File: rtl/fuse_seq_dpath.sv
module fuse_seq_dpath
  import fuse_seq_pkg::*;
#(
  parameter int STAGE_WORDS = 11,
  parameter int WORD_AW = 4,
  parameter int BIT_AW = WORD_AW + 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [5:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [31:0]       fuseRdata,
  input  seq_strobe_t       strb,
  input  seq_state_e        state,
  input  logic [BIT_AW-1:0] bitIdx,
  input  logic              csN,
  input  logic              pgmN,
  input  logic              strobe,
  input  logic              load,
  input  logic              vddq,
  output logic              cmdRd,
  output logic              cmdPgm,
  output logic [1:0]        blk,
  output seq_timing_t       tim,
  output logic              curBit,
  output logic              irq
);

  logic [31:0] stage [STAGE_WORDS];
  logic [31:0] rdBuf [STAGE_WORDS];
  logic [15:0] key;
  logic [1:0]  intRaw, intEna;

  logic               inWindow, isStage, isRdBuf;
  logic [WORD_AW-1:0] wIdx;
  assign inWindow = ({2'b00, regAddr[3:0]} < 6'(STAGE_WORDS));
  assign isStage  = (regAddr[5:4] == 2'b00) && inWindow;
  assign isRdBuf  = (regAddr[5:4] == 2'b10) && inWindow;
  assign wIdx     = regAddr[WORD_AW-1:0];

  logic cmdWr, cmdFree;
  assign cmdWr   = regWr && (regAddr == A_CMD);
  assign cmdFree = !cmdRd && !cmdPgm;

  generate
    for (genvar g = 0; g < STAGE_WORDS; g++) begin : g_word
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stage[g] <= '0;
          rdBuf[g] <= '0;
        end else begin
          if (regWr && isStage && wIdx == WORD_AW'(g)) stage[g] <= regWdata;
          if (strb.capture && bitIdx[BIT_AW-1:5] == WORD_AW'(g)) rdBuf[g] <= fuseRdata;
        end
      end
    end
  endgenerate

  assign curBit = stage[bitIdx[BIT_AW-1:5]][bitIdx[4:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      key    <= '0;
      cmdRd  <= 1'b0;
      cmdPgm <= 1'b0;
      blk    <= '0;
      intRaw <= '0;
      intEna <= '0;
      tim.rdInit  <= 8'd18;
      tim.rdSetup <= 8'd1;
      tim.rdPulse <= 8'd2;
      tim.rdHold  <= 8'd1;
      tim.pgSetup <= 8'd1;
      tim.pgHold  <= 8'd1;
      tim.pgZero  <= 8'd1;
      tim.pgOne   <= 16'd200;
      tim.pwrOn   <= 16'd12288;
      tim.pwrOff  <= 16'd400;
    end else begin
      if (regWr) begin
        unique case (regAddr)
          A_KEY:    key <= regWdata[15:0];
          A_RDTIM:  {tim.rdInit, tim.rdHold, tim.rdPulse, tim.rdSetup} <= regWdata;
          A_PGTIM0: {tim.pgOne, tim.pgZero, tim.pgSetup} <= regWdata;
          A_PGTIM1: {tim.pwrOn, tim.pgHold} <= regWdata[23:0];
          A_PWROFF: tim.pwrOff <= regWdata[15:0];
          A_INTENA: intEna <= regWdata[1:0];
          default: ;
        endcase
      end
      // command acceptance: read bit wins when both are written
      if (cmdWr && cmdFree) begin
        if (regWdata[0]) begin
          if (key == KEY_RD) begin
            cmdRd <= 1'b1;
            blk   <= regWdata[3:2];
          end
        end else if (regWdata[1] && key == KEY_PGM) begin
          cmdPgm <= 1'b1;
          blk    <= regWdata[3:2];
        end
      end
      if (strb.rdDone)  cmdRd  <= 1'b0;
      if (strb.pgmDone) cmdPgm <= 1'b0;
      // set beats clear in the same cycle
      intRaw[0] <= strb.rdDone  | (intRaw[0] & ~(regWr && regAddr == A_INTCLR && regWdata[0]));
      intRaw[1] <= strb.pgmDone | (intRaw[1] & ~(regWr && regAddr == A_INTCLR && regWdata[1]));
    end
  end

  assign irq = |(intRaw & intEna);

  always_comb begin
    regRdata = '0;
    if (isStage) regRdata = stage[wIdx];
    else if (isRdBuf) regRdata = rdBuf[wIdx];
    else begin
      unique case (regAddr)
        A_KEY:    regRdata = {16'd0, key};
        A_CMD:    regRdata = {28'd0, blk, cmdPgm, cmdRd};
        A_RDTIM:  regRdata = {tim.rdInit, tim.rdHold, tim.rdPulse, tim.rdSetup};
        A_PGTIM0: regRdata = {tim.pgOne, tim.pgZero, tim.pgSetup};
        A_PGTIM1: regRdata = {8'd0, tim.pwrOn, tim.pgHold};
        A_PWROFF: regRdata = {16'd0, tim.pwrOff};
        A_STATUS: regRdata = {23'd0, pgmN, csN, strobe, vddq, load, state};
        A_INTRAW: regRdata = {30'd0, intRaw};
        A_INTENA: regRdata = {30'd0, intEna};
        A_INTST:  regRdata = {30'd0, intRaw & intEna};
        default:  regRdata = '0;
      endcase
    end
  end

  // R3
  rd_selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdRd) |-> $past(strb.rdDone));

  // R3
  pgm_selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdPgm) |-> $past(strb.pgmDone));

  // R1
  pgm_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdPgm) |-> ($past(key) == KEY_PGM));

  // R8
  raw_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intRaw[1]) |-> $past(strb.pgmDone));

endmodule

// File: rtl/fuse_sequencer.sv
module fuse_sequencer
  import fuse_seq_pkg::*;
#(
  parameter int DATA_WORDS = 8,
  parameter int CHK_WORDS = 3,
  localparam int STAGE_WORDS = DATA_WORDS + CHK_WORDS,
  localparam int WORD_AW = (STAGE_WORDS > 1) ? $clog2(STAGE_WORDS) : 1,
  localparam int BIT_AW = WORD_AW + 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [5:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              fuseCsN,
  output logic              fusePgmN,
  output logic              fuseStrobe,
  output logic              fuseLoad,
  output logic              fuseVddq,
  output logic [1:0]        fuseBlk,
  output logic [BIT_AW-1:0] fuseAddr,
  input  logic [31:0]       fuseRdata,
  output logic              irq
);

  seq_state_e  state;
  seq_strobe_t strb;
  seq_timing_t tim;
  logic        cmdRd, cmdPgm, curBit;

  fuse_seq_ctrl #(.STAGE_WORDS(STAGE_WORDS), .WORD_AW(WORD_AW), .BIT_AW(BIT_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .startRd(cmdRd), .startPgm(cmdPgm), .tim(tim),
    .curBit(curBit), .state(state), .strb(strb), .bitIdx(fuseAddr),
    .csN(fuseCsN), .pgmN(fusePgmN), .strobe(fuseStrobe), .load(fuseLoad), .vddq(fuseVddq)
  );

  fuse_seq_dpath #(.STAGE_WORDS(STAGE_WORDS), .WORD_AW(WORD_AW), .BIT_AW(BIT_AW)) u_dpath (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .fuseRdata(fuseRdata), .strb(strb), .state(state),
    .bitIdx(fuseAddr), .csN(fuseCsN), .pgmN(fusePgmN), .strobe(fuseStrobe),
    .load(fuseLoad), .vddq(fuseVddq), .cmdRd(cmdRd), .cmdPgm(cmdPgm), .blk(fuseBlk),
    .tim(tim), .curBit(curBit), .irq(irq)
  );

endmodule

// File: tb/fuse_sequencer_test.sv
`timescale 1ns/1ps
module fuse_sequencer_test;

  localparam int NW = 3;
  localparam int NB = NW * 32;
  localparam int AW = 7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        fuseCsN, fusePgmN, fuseStrobe, fuseLoad, fuseVddq, irq;
  logic [1:0]  fuseBlk;
  logic [AW-1:0] fuseAddr;
  logic [31:0] fuseRdata;

  always #2.5 clk = ~clk;

  fuse_sequencer #(.DATA_WORDS(2), .CHK_WORDS(1)) uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .fuseCsN(fuseCsN), .fusePgmN(fusePgmN), .fuseStrobe(fuseStrobe),
    .fuseLoad(fuseLoad), .fuseVddq(fuseVddq), .fuseBlk(fuseBlk), .fuseAddr(fuseAddr),
    .fuseRdata(fuseRdata), .irq(irq)
  );

  // behavioural fuse array
  logic [NB-1:0] mem [4];
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < 4; b++) mem[b] <= '0;
    end else if (!fuseCsN && !fusePgmN && fuseStrobe && fuseVddq) begin
      mem[fuseBlk][fuseAddr] <= 1'b1;
    end
  end
  assign fuseRdata = mem[fuseBlk][fuseAddr +: 32];

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  int vddqCnt, strobeCnt, loadCnt;

  always @(negedge clk) begin
    if (fuseVddq) vddqCnt++;
    if (fuseStrobe) strobeCnt++;
    if (fuseLoad) loadCnt++;
  end

  typedef struct packed {
    logic [1:0]    blk;
    logic [NB-1:0] pat;   // word0 in [31:0]
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{2'd1, {32'h0000_0000, 32'h8000_0000, 32'h0000_0001}},
    '{2'd2, {32'hA5A5_0F0F, 32'h0000_FFFF, 32'hFFFF_FFFF}},
    '{2'd1, {32'h0000_0000, 32'h1234_5678, 32'h0000_0100}},
    '{2'd3, {32'h0000_0000, 32'h0000_0000, 32'h0000_0000}}
  };

  logic [NB-1:0] shadow [4];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic waitRaw(input int b);
    logic [31:0] d;
    for (int i = 0; i < 5000; i++) begin
      rd(6'h17, d);
      if (d[b]) return;
    end
  endtask

  task automatic readBlock(input logic [1:0] b, input string req);
    logic [31:0] d;
    wr(6'h1A, 32'h3);
    wr(6'h10, 32'h5AA5);
    loadCnt = 0; strobeCnt = 0;
    wr(6'h11, {28'd0, b, 2'b01});
    waitRaw(0);
    chk({req, " R7 load cycles"}, 32'(loadCnt), 32'd16);
    chk({req, " R7 read strobe cycles"}, 32'(strobeCnt), 32'd6);
    for (int w = 0; w < NW; w++) begin
      rd(6'(32 + w), d);
      chk({req, " R7 readback word"}, d, shadow[b][w*32 +: 32]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int b = 0; b < 4; b++) shadow[b] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R10 reset state
    rd(6'h12, d); chk("R10 read timing", d, 32'h1201_0201);
    rd(6'h13, d); chk("R10 program timing", d, 32'h00C8_0101);
    rd(6'h14, d); chk("R10 power-up", d, 32'h0030_0001);
    rd(6'h15, d); chk("R10 power-off", d, 32'h0000_0190);
    rd(6'h16, d); chk("R10 status", d, 32'h180);
    chk("R10 pins", {27'd0, fuseCsN, fusePgmN, fuseStrobe, fuseLoad, fuseVddq}, 32'h18);

    wr(6'h12, 32'h0401_0201);   // init 4, hold 1, pulse 2, setup 1
    wr(6'h13, 32'h0003_0201);   // one 3, zero 2, setup 1
    wr(6'h14, 32'h0000_0501);   // power-up 5, hold 1
    wr(6'h15, 32'h0000_0003);

    // R1 wrong key for each command
    wr(6'h10, 32'h5AA5);
    wr(6'h11, 32'h2);
    rd(6'h11, d); chk("R1 program with read key", d, 32'h0);
    rd(6'h16, d); chk("R1 stays idle", d, 32'h180);
    wr(6'h10, 32'h1234);
    wr(6'h11, 32'h1);
    rd(6'h11, d); chk("R1 read with bad key", d, 32'h0);

    // table walk: program then read back
    for (int v = 0; v < 4; v++) begin
      int ones;
      ones = $countones(VECS[v].pat);
      for (int w = 0; w < NW; w++) wr(6'(w), VECS[v].pat[w*32 +: 32]);
      wr(6'h1A, 32'h3);
      wr(6'h10, 32'h5A5A);
      vddqCnt = 0; strobeCnt = 0;
      wr(6'h11, {28'd0, VECS[v].blk, 2'b10});
      rd(6'h16, d); chk("R9 status in power-up", d, 32'h1A5);
      rd(6'h11, d); chk("R3 pending bit", d, {28'd0, VECS[v].blk, 2'b10});
      // R4 busy write with another block
      wr(6'h11, {28'd0, 2'd0, 2'b10});
      waitRaw(1);
      chk("R6 supply cycles", 32'(vddqCnt), 32'(5 + NB * 2 + ones * 3 + (NB - ones) * 2));
      chk("R6 burn strobe cycles", 32'(strobeCnt), 32'(ones * 3));
      rd(6'h11, d); chk("R3 self-clear", d, {28'd0, VECS[v].blk, 2'b00});
      rd(6'h16, d); chk("R4 no follow-on operation", d, 32'h180);
      rd(6'h17, d); chk("R8 program raw only", d, 32'h2);
      shadow[VECS[v].blk] = shadow[VECS[v].blk] | VECS[v].pat;
      readBlock(VECS[v].blk, "R5");
    end

    // R5 untouched block
    readBlock(2'd0, "R5 block0");

    // R2 both bits with read key
    wr(6'h1A, 32'h3);
    wr(6'h10, 32'h5AA5);
    wr(6'h11, {28'd0, 2'd1, 2'b11});
    waitRaw(0);
    repeat (3) @(negedge clk);
    rd(6'h17, d); chk("R2 only read done", d, 32'h1);
    rd(6'h20, d); chk("R2 read data", d, shadow[1][31:0]);

    // R8 enable, status, clear
    wr(6'h18, 32'h0);
    rd(6'h19, d); chk("R8 masked status", d, 32'h0);
    chk("R8 masked irq", {31'd0, irq}, 32'h0);
    wr(6'h18, 32'h1);
    rd(6'h19, d); chk("R8 enabled status", d, 32'h1);
    chk("R8 irq", {31'd0, irq}, 32'h1);
    wr(6'h1A, 32'h1);
    rd(6'h17, d); chk("R8 cleared raw", d, 32'h0);
    chk("R8 irq after clear", {31'd0, irq}, 32'h0);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule